// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Associative Eviction Buffer

The block is a small direct-mapped data cache with a four-entry, fully associative buffer of evicted lines beside it. A load first probes the single slot that its index field selects. If that probe misses, the buffer entries are compared in parallel against the full line address. On a buffer match, the requested line and the slot's current line trade places in one step, and the load completes with no access to memory. If both probes miss, the whole line is fetched from the next level of memory. The displaced line, if it was valid, then goes into the buffer, where it replaces the entry that has been there longest.

Stores follow a write-through, no-write-allocate policy. Every store is sent to memory as a single word write. A copy held in the array or in the buffer is updated in place, and a store that misses installs nothing. Because of this, a line that leaves the cache never has to be written back. The processor side presents one request at a time while `cpu_wait` is low. It then sees `cpu_wait` high until a one-cycle `cpu_done` pulse returns the data word together with flags that say where the line was found.

Top module: `dmv_cache`

## Requirements
- R1: After reset, `cpu_wait`, `cpu_done` and `mem_req` are low, and both the array and the buffer hold no valid line, so the first access to any line is a full miss.
- R2: A load whose line is valid in the indexed slot with a matching tag completes with `cpu_done` on the second rising edge after the request is sampled, with `cpu_hit`=1, `cpu_vhit`=0 and no memory request.
- R3: The word address splits into offset (low OFS_W bits), index (next IDX_W bits) and tag (remaining upper bits), and the returned word is word number `offset` of the line, where word w occupies line bits [w*WORD_W +: WORD_W].
- R4: A load that misses the slot but matches a valid buffer entry completes on the second edge with `cpu_vhit`=1 and `cpu_hit`=0, without a memory request. The line moves into the slot, and the line that was in the slot takes over that same buffer entry.
- R5: A load that misses both issues one memory read with `mem_we`=0 at the line-aligned address (offset bits zero). The load returns word `offset` of `mem_rline` with both flags low.
- R6: Only valid lines pushed out of the slot by a full-miss fill enter the buffer, and each such line replaces the entry that has been filled longest (first in, first out over the 4 entries).
- R7: Every store issues exactly one memory write of `cpu_wdata` to `cpu_addr`. A cached copy in the slot or in the buffer is updated, while a store miss allocates nothing. The flags report where the line was found.
- R8: `cpu_wait` is high on every cycle from the edge after acceptance until the completion edge. `cpu_done` is a single-cycle pulse, and `cpu_wait` is low while it is high.
- R9: `mem_req` stays high with unchanged command until the cycle in which `mem_ack` is sampled, and it is raised only for full load misses and for stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, sampled while `cpu_wait` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_wait | output | 1 | Request in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Load data, valid with `cpu_done` |
| cpu_hit | output | 1 | Line was found in the direct-mapped slot |
| cpu_vhit | output | 1 | Line was found in the eviction buffer |
| mem_req | output | 1 | Memory command pending |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | ADDR_W | Word address (line-aligned for reads) |
| mem_wdata | output | WORD_W | Write data |
| mem_ack | input | 1 | Memory command completes; line data valid for reads |
| mem_rline | input | WORD_W*2**OFS_W | Fetched line |

## Verification
A corrupted tag, a wrong valid bit or a broken swap shows up at the ports on the next access to the affected line: the hit flags differ from the expected classification, or a memory read appears where none should, usually within a few operations. A bad FIFO pointer is only visible once the buffer wraps, so conflict rings of two to six lines on one index are replayed until each line has been displaced more than once. Stale data after a store is caught by reading the stored word back from its slot, from the buffer, and after a no-allocate miss.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2,
    ST_WRT  = 2'd3
  } dmv_state_e;
endpackage

// File: rtl/dmv_line_store.sv
module dmv_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int LINES = 1 << IDX_W;
  localparam int ENT_W = TAG_W + LINE_W;

  // tag and data in one RAM without reset, so block RAM can be inferred
  logic [ENT_W-1:0] ram [LINES];
  logic [ENT_W-1:0] rd_q;
  logic [LINES-1:0] valid;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= {wr_tag, wr_line};
    if (rd_en) rd_q <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid[rd_idx];
    end
  end

  assign rd_tag  = rd_q[ENT_W-1 -: TAG_W];
  assign rd_line = rd_q[LINE_W-1:0];

  // R1: nothing becomes valid without a write
  p_valid_needs_write_r1: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> (valid == $past(valid)));
endmodule

// File: rtl/dmv_victim_buf.sv
module dmv_victim_buf #(
  parameter int ENTRIES = 4,
  parameter int LADDR_W = 10,
  parameter int LINE_W  = 128,
  localparam int VIDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LADDR_W-1:0] lk_laddr,
  output logic               lk_hit,
  output logic [VIDX_W-1:0]  lk_idx,
  output logic [LINE_W-1:0]  lk_line,
  input  logic               wr_en,
  input  logic               wr_use_fifo,
  input  logic [VIDX_W-1:0]  wr_idx,
  input  logic [LADDR_W-1:0] wr_laddr,
  input  logic [LINE_W-1:0]  wr_line,
  input  logic               wr_valid
);
  logic [LADDR_W-1:0] ent_la   [ENTRIES];
  logic [LINE_W-1:0]  ent_line [ENTRIES];
  logic [ENTRIES-1:0] ent_v;
  logic [ENTRIES-1:0] hit_vec;
  logic [VIDX_W-1:0]  fifo_ptr;
  logic [VIDX_W-1:0]  widx;

  // one comparator per entry, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] && (ent_la[g] == lk_laddr);
  end

  always_comb begin
    lk_idx  = '0;
    lk_line = ent_line[0];
    for (int k = 0; k < ENTRIES; k++) begin
      if (hit_vec[k]) begin
        lk_idx  = VIDX_W'(k);
        lk_line = ent_line[k];
      end
    end
  end
  assign lk_hit = |hit_vec;

  assign widx = wr_use_fifo ? fifo_ptr : wr_idx;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_la[widx]   <= wr_laddr;
      ent_line[widx] <= wr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v    <= '0;
      fifo_ptr <= '0;
    end else if (wr_en) begin
      ent_v[widx] <= wr_valid;
      if (wr_use_fifo) begin
        if (fifo_ptr == VIDX_W'(ENTRIES - 1)) fifo_ptr <= '0;
        else                                  fifo_ptr <= fifo_ptr + 1'b1;
      end
    end
  end

  // R4: a line address is never held by two entries
  p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R6: swaps in place leave the FIFO order untouched
  p_swap_keeps_order_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_use_fifo) |=> $stable(fifo_ptr));
  // R6: insertion after the last entry wraps to the first
  p_fifo_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_use_fifo && fifo_ptr == VIDX_W'(ENTRIES - 1)) |=> (fifo_ptr == '0));
endmodule

// File: rtl/dmv_cache.sv
module dmv_cache #(
  parameter int ADDR_W  = 12,
  parameter int WORD_W  = 32,
  parameter int OFS_W   = 2,
  parameter int IDX_W   = 3,
  parameter int VICTIMS = 4,
  localparam int LINE_W = WORD_W * (1 << OFS_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_wait,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_vhit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rline
);
  import dmv_pkg::*;

  localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;
  localparam int LADDR_W = ADDR_W - OFS_W;
  localparam int VIDX_W  = (VICTIMS > 1) ? $clog2(VICTIMS) : 1;

  dmv_state_e        state;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [WORD_W-1:0] r_wdata;

  logic [OFS_W-1:0]   r_ofs;
  logic [IDX_W-1:0]   r_idx;
  logic [TAG_W-1:0]   r_tag;
  logic [LADDR_W-1:0] r_laddr;

  assign r_ofs   = r_addr[OFS_W-1:0];
  assign r_idx   = r_addr[OFS_W +: IDX_W];
  assign r_tag   = r_addr[ADDR_W-1 -: TAG_W];
  assign r_laddr = r_addr[ADDR_W-1:OFS_W];

  // direct-mapped array
  logic              ls_rd_en;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              ls_we;
  logic [LINE_W-1:0] ls_line;

  assign ls_rd_en = (state == ST_IDLE) && cpu_req;

  dmv_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(ls_rd_en), .rd_idx(cpu_addr[OFS_W +: IDX_W]),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line),
    .wr_en(ls_we), .wr_idx(r_idx), .wr_tag(r_tag), .wr_line(ls_line)
  );

  // eviction buffer
  logic               vb_hit;
  logic [VIDX_W-1:0]  vb_idx;
  logic [LINE_W-1:0]  vb_line;
  logic               vb_we;
  logic               vb_fifo;
  logic [LADDR_W-1:0] vb_wla;
  logic [LINE_W-1:0]  vb_wline;
  logic               vb_wvalid;

  dmv_victim_buf #(.ENTRIES(VICTIMS), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_vbuf (
    .clk(clk), .rst(rst),
    .lk_laddr(r_laddr), .lk_hit(vb_hit), .lk_idx(vb_idx), .lk_line(vb_line),
    .wr_en(vb_we), .wr_use_fifo(vb_fifo), .wr_idx(vb_idx),
    .wr_laddr(vb_wla), .wr_line(vb_wline), .wr_valid(vb_wvalid)
  );

  logic              main_hit;
  logic [WORD_W-1:0] main_word;
  logic [WORD_W-1:0] vb_word;
  logic [WORD_W-1:0] fill_word;
  logic [LINE_W-1:0] main_merged;
  logic [LINE_W-1:0] vb_merged;

  assign main_hit  = rd_valid && (rd_tag == r_tag);
  assign main_word = rd_line[r_ofs*WORD_W +: WORD_W];
  assign vb_word   = vb_line[r_ofs*WORD_W +: WORD_W];
  assign fill_word = mem_rline[r_ofs*WORD_W +: WORD_W];

  always_comb begin
    main_merged = rd_line;
    main_merged[r_ofs*WORD_W +: WORD_W] = r_wdata;
    vb_merged = vb_line;
    vb_merged[r_ofs*WORD_W +: WORD_W] = r_wdata;
  end

  // write steering for array and buffer
  always_comb begin
    ls_we     = 1'b0;
    ls_line   = rd_line;
    vb_we     = 1'b0;
    vb_fifo   = 1'b0;
    vb_wla    = {rd_tag, r_idx};
    vb_wline  = rd_line;
    vb_wvalid = rd_valid;
    if (state == ST_LOOK) begin
      if (r_we) begin
        if (main_hit) begin
          ls_we   = 1'b1;
          ls_line = main_merged;
        end else if (vb_hit) begin
          vb_we     = 1'b1;
          vb_wla    = r_laddr;
          vb_wline  = vb_merged;
          vb_wvalid = 1'b1;
        end
      end else if (!main_hit && vb_hit) begin
        ls_we   = 1'b1;
        ls_line = vb_line;
        vb_we   = 1'b1;
      end
    end else if (state == ST_FILL && mem_ack) begin
      ls_we   = 1'b1;
      ls_line = mem_rline;
      vb_we   = rd_valid;
      vb_fifo = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      cpu_wait  <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      cpu_hit   <= 1'b0;
      cpu_vhit  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            r_we     <= cpu_we;
            r_addr   <= cpu_addr;
            r_wdata  <= cpu_wdata;
            cpu_wait <= 1'b1;
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (r_we) begin
            cpu_hit   <= main_hit;
            cpu_vhit  <= !main_hit && vb_hit;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= r_addr;
            mem_wdata <= r_wdata;
            state     <= ST_WRT;
          end else if (main_hit) begin
            cpu_rdata <= main_word;
            cpu_hit   <= 1'b1;
            cpu_vhit  <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_wait  <= 1'b0;
            state     <= ST_IDLE;
          end else if (vb_hit) begin
            cpu_rdata <= vb_word;
            cpu_hit   <= 1'b0;
            cpu_vhit  <= 1'b1;
            cpu_done  <= 1'b1;
            cpu_wait  <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {r_laddr, {OFS_W{1'b0}}};
            state    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_rdata <= fill_word;
            cpu_hit   <= 1'b0;
            cpu_vhit  <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_wait  <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_WRT: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            cpu_done <= 1'b1;
            cpu_wait <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single pulse with wait released
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
  p_wait_low_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_wait);
  // R9: a pending memory command holds until acknowledged
  p_memreq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R2: loads found in the cache raise no memory command
  p_no_mem_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && !r_we && (main_hit || vb_hit)) |=> !mem_req);
  // R4: the two location flags are exclusive
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(cpu_hit && cpu_vhit));
  // R5: line reads are line aligned
  p_fill_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr[OFS_W-1:0] == '0));
endmodule

// File: tb/dmv_cache_tb.sv
module dmv_cache_tb;
  localparam int AW = 10;
  localparam int WW = 32;
  localparam int OW = 2;
  localparam int IW = 2;
  localparam int NV = 4;
  localparam int LW = WW * (1 << OW);
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [WW-1:0] cpu_wdata = '0;
  logic          cpu_wait, cpu_done, cpu_hit, cpu_vhit;
  logic [WW-1:0] cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [LW-1:0] mem_rline = '0;

  always #2.5 clk = ~clk;

  dmv_cache #(.ADDR_W(AW), .WORD_W(WW), .OFS_W(OW), .IDX_W(IW), .VICTIMS(NV)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_vhit(cpu_vhit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rline(mem_rline)
  );

  int nvec = 0;
  int nfail = 0;
  logic [WW-1:0] bmem [1 << AW];
  int n_rd = 0;
  int n_wr = 0;
  int lat_cnt = 0;
  logic [AW-1:0] last_raddr = '0;
  logic [AW-1:0] last_waddr = '0;
  logic [WW-1:0] last_wdata = '0;

  // reference placement state
  logic [AW-OW-1:0] m_la [NL];
  logic             m_v  [NL];
  logic [AW-OW-1:0] v_la [NV];
  logic             v_v  [NV];
  int               v_ptr;

  task automatic chk(input logic ok, input string req, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: fixed latency, writes update the array
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 2) begin
        lat_cnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata;
          last_waddr = mem_addr;
          last_wdata = mem_wdata;
          n_wr++;
        end else begin
          last_raddr = mem_addr;
          for (int w = 0; w < (1 << OW); w++)
            mem_rline[w*WW +: WW] = bmem[{mem_addr[AW-1:OW], OW'(w)}];
          n_rd++;
        end
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin m_la[i] = '0; m_v[i] = 1'b0; end
    for (int i = 0; i < NV; i++) begin v_la[i] = '0; v_v[i] = 1'b0; end
    v_ptr = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cpu_req = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(cpu_wait == 1'b0, "R1 wait", WW'(cpu_wait), 0);
    chk(cpu_done == 1'b0, "R1 done", WW'(cpu_done), 0);
    chk(mem_req == 1'b0, "R1 mem_req", WW'(mem_req), 0);
  endtask

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [WW-1:0] wd,
                       input string tag);
    logic [AW-OW-1:0] la;
    logic [IW-1:0]    ix;
    logic             eh, ev, wait_ok;
    int               vk, rd0, wr0, cyc;
    logic [WW-1:0]    ed;
    la = a[AW-1:OW];
    ix = a[OW +: IW];
    eh = m_v[ix] && (m_la[ix] == la);
    ev = 1'b0;
    vk = 0;
    if (!eh)
      for (int k = 0; k < NV; k++)
        if (v_v[k] && v_la[k] == la) begin ev = 1'b1; vk = k; end
    ed  = bmem[a];
    rd0 = n_rd;
    wr0 = n_wr;
    if (!we) begin
      if (ev) begin
        v_la[vk] = m_la[ix];
        v_v[vk]  = m_v[ix];
        m_la[ix] = la;
        m_v[ix]  = 1'b1;
      end else if (!eh) begin
        if (m_v[ix]) begin
          v_la[v_ptr] = m_la[ix];
          v_v[v_ptr]  = 1'b1;
          v_ptr = (v_ptr + 1) % NV;
        end
        m_la[ix] = la;
        m_v[ix]  = 1'b1;
      end
    end
    chk(cpu_done == 1'b0, "R8 pulse", WW'(cpu_done), 0);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 1;
    wait_ok = 1'b1;
    while (!cpu_done && cyc < 60) begin
      if (!cpu_wait) wait_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(wait_ok, "R8 wait held", WW'(wait_ok), 1);
    chk(cpu_done == 1'b1, "R8 completion", WW'(cpu_done), 1);
    chk(cpu_wait == 1'b0, "R8 wait at done", WW'(cpu_wait), 0);
    chk(cpu_hit == eh, {tag, " hit flag"}, WW'(cpu_hit), WW'(eh));
    chk(cpu_vhit == ev, {tag, " vhit flag"}, WW'(cpu_vhit), WW'(ev));
    if (we) begin
      chk(n_wr - wr0 == 1 && n_rd == rd0, "R7 one write", WW'(n_wr - wr0), 1);
      chk(last_waddr == a && last_wdata == wd, "R7 write addr/data", WW'(last_waddr), WW'(a));
    end else begin
      chk(cpu_rdata == ed, {tag, " R3 data"}, cpu_rdata, ed);
      if (eh || ev) begin
        chk(cyc == 2, "R2 R4 latency", WW'(cyc), 2);
        chk(n_rd == rd0 && n_wr == wr0, "R9 no mem on hit", WW'(n_rd - rd0), 0);
      end else begin
        chk(n_rd - rd0 == 1, "R5 one fill", WW'(n_rd - rd0), 1);
        chk(last_raddr == {la, {OW{1'b0}}}, "R5 aligned", WW'(last_raddr),
            WW'({la, {OW{1'b0}}}));
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int a = 0; a < (1 << AW); a++) bmem[a] = (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    model_reset();
    do_reset();

    // R6: six lines on index 3, then oldest-first displacement
    for (int j = 0; j < 6; j++) do_op(1'b0, AW'((j * NL + 3) * 4 + (j % 4)), '0, "R6 fill");
    do_op(1'b0, AW'((0 * NL + 3) * 4), '0, "R6 oldest gone");
    do_op(1'b0, AW'((2 * NL + 3) * 4 + 1), '0, "R6 kept");
    do_op(1'b0, AW'((1 * NL + 3) * 4 + 2), '0, "R6 second gone");

    do_reset();
    // R3 R5 R2: every word of 16 lines
    for (int l = 0; l < 16; l++)
      for (int w = 0; w < 4; w++) do_op(1'b0, AW'(l * 4 + w), '0, "R2 R5 sweep");

    // R4 R6: conflict rings of k lines on one index
    for (int k = 2; k <= 6; k++)
      for (int r = 0; r < 4; r++)
        for (int j = 0; j < k; j++)
          do_op(1'b0, AW'(((40 + j + 8 * k) * NL + (k % NL)) * 4 + ((j + r) % 4)), '0, "R4 ring");

    // R7: store then load back, cached and uncached
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 96; i++) begin
      logic [AW-1:0] a;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = AW'(seed[23:14]) & AW'((i % 3 == 0) ? 10'h3FF : 10'h07F);
      do_op(1'b1, a, seed ^ 32'hC0DE_0000, "R7 store");
      do_op(1'b0, a, '0, "R7 readback");
    end

    // mixed traffic over a compact region
    for (int i = 0; i < 1500; i++) begin
      logic [AW-1:0] a;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = AW'(seed[25:16]) & ((seed[3:0] == 0) ? 10'h3FF : 10'h05F);
      do_op(seed[29:28] == 2'b00, a, seed, "R2 R4 R5 R7 mixed");
    end

    do_reset();
    do_op(1'b1, 10'h155, 32'hDEAD_BEEF, "R7 cold store");
    do_op(1'b0, 10'h155, '0, "R7 no allocate");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule